// File: doc/BRIEF.md
# Programmable Sample-Rate Strobe Generator

This block divides a fast reference clock down to an audio sample rate and marks every sample instant with a strobe one clock wide. The reference frequency is a parameter (`REF_HZ`, default 677 376 000). A 32-bit control word picks the rate. Its low four bits select one of nine fixed standard rates or a continuous-rate mode. In continuous mode a 16-bit frequency register sets the interval directly, and software can retune the rate by rewriting that register alone, for example to follow a time-code source.

Every write is judged as a whole before anything is stored. An illegal setting raises an error flag and leaves both the stored settings and the running interval untouched. A legal setting is not applied at once. The interval already in progress always completes at its old length, and the new length starts at the following strobe, so no short or stretched interval is ever produced. The current interval length is always visible on `period_out`.

Control sits in a two-state machine. `ST_STEADY` means no change is waiting. `ST_PENDING` means an accepted setting is held for the next boundary. The transition `accept_mid_period` (STEADY to PENDING) happens when a legal write arrives in any cycle except the last cycle of an interval. The transition `reload_at_boundary` (PENDING to STEADY) happens when the last cycle of an interval is reached. The transition `accept_at_boundary` (stay in STEADY) applies a write that lands in the last cycle straight to the next interval. The transition `overwrite_pending` (stay in PENDING) replaces a waiting value with a newer one.

Top module: `srg_strobe_gen`

## Requirements
- R1: On synchronous active-high reset the interval P becomes REF_HZ/48000, `cfg_err` is 0 and `strobe` is low. Counting the first cycle with reset low as cycle 1, `strobe` is high in cycle P, and again every P cycles after that, each time for exactly one cycle.
- R2: Select codes in `ctrl_word[3:0]` give these intervals: 0x2 → REF_HZ/48000, 0x3 → REF_HZ/44100, 0x4 → REF_HZ/32000, 0x5 → REF_HZ/22050, 0x6 → REF_HZ/16000, 0x7 → REF_HZ/11025, 0x8 → REF_HZ/8000. For these codes the double-speed bit `ctrl_word[14]` has no effect.
- R3: Code 0x0 (REF_HZ/96000) and code 0x1 (REF_HZ/88200) are accepted only when `ctrl_word[14]` is 1. Without that bit they are rejected.
- R4: Codes 0x9 to 0xD and code 0xF are always rejected.
- R5: Code 0xE selects continuous mode, in which P equals the frequency register plus 2. The frequency register is written from `freq_word` on `freq_wr`, and it resets to REF_HZ/48000 − 2.
- R6: In continuous mode with `ctrl_word[14]` = 0, a setting is accepted only if ceil(REF_HZ/50000) ≤ P ≤ floor(REF_HZ/25000). With `ctrl_word[14]` = 1 the bounds are ceil(REF_HZ/100000) ≤ P ≤ floor(REF_HZ/50000).
- R7: Once continuous mode is stored, a `freq_wr` on its own changes the rate. While a fixed code is stored, a `freq_wr` is stored without changing the interval.
- R8: A rejected write changes neither the stored settings nor the interval, and `cfg_err` reads 1 from the next cycle on. The next accepted write clears `cfg_err`, again from the next cycle on.
- R9: An accepted write made before the last cycle of an interval leaves that interval at its old length. `period_out` changes in the cycle after that interval's strobe.
- R10: A write accepted in a strobe cycle sets the length of the very next interval. When two writes are accepted within one interval, the later one wins.
- R11: When `ctrl_wr` and `freq_wr` are asserted in the same cycle, both new values are judged together as one setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_word | input | 32 | Control word: [3:0] select code, [14] double speed |
| freq_wr | input | 1 | Write strobe for the frequency register |
| freq_word | input | FREQ_W (16) | Continuous-mode frequency register value |
| strobe | output | 1 | One-cycle sample strobe |
| period_out | output | CNT_W (17) | Length in cycles of the interval now running |
| cfg_err | output | 1 | Last write was rejected |

## Verification
The two functions that can coincide are the acceptance of a new setting and the end of the running interval. The bench provokes this on purpose: it waits until it sees the strobe, then drives the write in that same cycle. The result is judged by measuring the next strobe-to-strobe distance, which must already equal the new length. A second scenario stacks two accepted writes inside one interval and requires that the interval finishes at its old length and the following one uses the later value.

// File: rtl/srg_pkg.sv
package srg_pkg;

    typedef enum logic [0:0] {
        ST_STEADY  = 1'b0,
        ST_PENDING = 1'b1
    } srg_state_e;

    localparam int unsigned SEL_W     = 4;
    localparam int unsigned DBL_POS   = 14;
    localparam int unsigned NUM_FIXED = 9;
    localparam logic [SEL_W-1:0] SEL_CONT  = 4'hE;
    localparam logic [SEL_W-1:0] SEL_RESET = 4'h2;

    localparam longint unsigned CONT_SS_LO_HZ = 25000;
    localparam longint unsigned CONT_SS_HI_HZ = 50000;
    localparam longint unsigned CONT_DS_HI_HZ = 100000;
    localparam longint unsigned DEFAULT_HZ    = 48000;

    function automatic longint unsigned fixed_rate_hz(input int unsigned sel);
        case (sel)
            0:       return 96000;
            1:       return 88200;
            2:       return 48000;
            3:       return 44100;
            4:       return 32000;
            5:       return 22050;
            6:       return 16000;
            7:       return 11025;
            8:       return 8000;
            default: return 1;
        endcase
    endfunction

    function automatic longint unsigned ceil_div(input longint unsigned a,
                                                 input longint unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned period_width(input longint unsigned ref_hz,
                                                 input int unsigned freq_w);
        longint unsigned top_p;
        top_p = (64'd1 << freq_w) + 64'd1;
        for (int s = 0; s < NUM_FIXED; s++) begin
            if (ref_hz / fixed_rate_hz(s) > top_p) top_p = ref_hz / fixed_rate_hz(s);
        end
        return $clog2(top_p + 64'd1);
    endfunction

endpackage

// File: rtl/srg_cfg_decode.sv
module srg_cfg_decode
    import srg_pkg::*;
#(
    parameter int unsigned REF_HZ = 677376000,
    parameter int unsigned FREQ_W = 16,
    parameter int unsigned CNT_W  = 17
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              dbl,
    input  logic [FREQ_W-1:0] freq,
    output logic [CNT_W-1:0]  period,
    output logic              legal
);

    localparam longint unsigned REF_L = 64'(REF_HZ);
    localparam logic [CNT_W-1:0] SS_MIN = CNT_W'(ceil_div(REF_L, CONT_SS_HI_HZ));
    localparam logic [CNT_W-1:0] SS_MAX = CNT_W'(REF_L / CONT_SS_LO_HZ);
    localparam logic [CNT_W-1:0] DS_MIN = CNT_W'(ceil_div(REF_L, CONT_DS_HI_HZ));
    localparam logic [CNT_W-1:0] DS_MAX = CNT_W'(REF_L / CONT_SS_HI_HZ);

    logic [CNT_W-1:0] fixed_div [16];
    logic [CNT_W-1:0] cont_p;

    for (genvar g = 0; g < 16; g++) begin : g_div
        if (g < NUM_FIXED) begin : g_rate
            localparam longint unsigned DIV = REF_L / fixed_rate_hz(g);
            assign fixed_div[g] = CNT_W'(DIV);
        end else begin : g_none
            assign fixed_div[g] = '0;
        end
    end

    assign cont_p = CNT_W'(freq) + CNT_W'(2);

    always_comb begin
        period = fixed_div[sel];
        legal  = 1'b0;
        if (sel == SEL_CONT) begin
            period = cont_p;
            legal  = dbl ? (cont_p >= DS_MIN && cont_p <= DS_MAX)
                         : (cont_p >= SS_MIN && cont_p <= SS_MAX);
        end else if (32'(sel) < NUM_FIXED) begin
            legal = (sel > 4'd1) || dbl;
        end
    end

endmodule

// File: rtl/srg_cfg_regs.sv
module srg_cfg_regs
    import srg_pkg::*;
#(
    parameter int unsigned REF_HZ = 677376000,
    parameter int unsigned FREQ_W = 16,
    parameter int unsigned CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              dbl_in,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_in,
    output logic              upd_valid,
    output logic [CNT_W-1:0]  upd_period,
    output logic              cfg_err
);

    localparam logic [FREQ_W-1:0] FREQ_RESET = FREQ_W'(64'(REF_HZ) / DEFAULT_HZ - 64'd2);

    logic [SEL_W-1:0]  sel_q,  cand_sel;
    logic              dbl_q,  cand_dbl;
    logic [FREQ_W-1:0] freq_q, cand_freq;
    logic              any_wr, cand_legal, err_q;

    // A write is judged with the unwritten half taken from the stored state.
    assign cand_sel  = ctrl_wr ? sel_in  : sel_q;
    assign cand_dbl  = ctrl_wr ? dbl_in  : dbl_q;
    assign cand_freq = freq_wr ? freq_in : freq_q;
    assign any_wr    = ctrl_wr | freq_wr;

    srg_cfg_decode #(
        .REF_HZ (REF_HZ),
        .FREQ_W (FREQ_W),
        .CNT_W  (CNT_W)
    ) decode_i (
        .sel    (cand_sel),
        .dbl    (cand_dbl),
        .freq   (cand_freq),
        .period (upd_period),
        .legal  (cand_legal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= SEL_RESET;
            dbl_q  <= 1'b0;
            freq_q <= FREQ_RESET;
            err_q  <= 1'b0;
        end else if (any_wr) begin
            if (cand_legal) begin
                sel_q  <= cand_sel;
                dbl_q  <= cand_dbl;
                freq_q <= cand_freq;
            end
            err_q <= ~cand_legal;
        end
    end

    assign upd_valid = any_wr & cand_legal;
    assign cfg_err   = err_q;

    a_r3_double_required: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && sel_in <= 4'd1 && !dbl_in) |=> cfg_err);

    a_r4_bad_select: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && sel_in != SEL_CONT && sel_in > 4'd8) |=> cfg_err);

    a_r8_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (any_wr && !cand_legal) |=> ($stable(sel_q) && $stable(dbl_q) && $stable(freq_q)));

    a_r8_accept_clears: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !cfg_err);

endmodule

// File: rtl/srg_period_fsm.sv
module srg_period_fsm
    import srg_pkg::*;
#(
    parameter int unsigned CNT_W  = 17,
    parameter int unsigned INIT_P = 14112
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic [CNT_W-1:0] upd_period,
    output logic             strobe,
    output logic [CNT_W-1:0] period_out
);

    srg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, per_q, pend_q;
    logic             boundary;

    assign boundary = (cnt_q == per_q - CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STEADY;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY: begin
                if (upd_valid && !boundary) state_d = ST_PENDING;  // accept_mid_period
            end
            ST_PENDING: begin
                if (boundary) state_d = ST_STEADY;                 // reload_at_boundary
            end
            default: state_d = ST_STEADY;
        endcase
    end

    // counter, running interval and waiting interval
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= CNT_W'(INIT_P);
            pend_q <= CNT_W'(INIT_P);
        end else begin
            if (upd_valid) pend_q <= upd_period;
            if (boundary) begin
                cnt_q <= '0;
                if (upd_valid)                    per_q <= upd_period;  // accept_at_boundary
                else if (state_q == ST_PENDING)   per_q <= pend_q;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        strobe     = boundary;
        period_out = per_q;
    end

    a_r1_count_in_period: assert property (@(posedge clk) disable iff (rst)
        cnt_q < per_q);

    a_r9_change_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(per_q) |-> $past(strobe));

    a_r10_same_cycle_update: assert property (@(posedge clk) disable iff (rst)
        (strobe && upd_valid) |=> (per_q == $past(upd_period)));

    a_r9_pending_applied: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING && strobe && !upd_valid) |=> (per_q == $past(pend_q)));

endmodule

// File: rtl/srg_strobe_gen.sv
module srg_strobe_gen
    import srg_pkg::*;
#(
    parameter  int unsigned REF_HZ = 677376000,
    parameter  int unsigned FREQ_W = 16,
    localparam int unsigned CNT_W  = period_width(64'(REF_HZ), FREQ_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [31:0]       ctrl_word,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_word,
    output logic              strobe,
    output logic [CNT_W-1:0]  period_out,
    output logic              cfg_err
);

    localparam int unsigned INIT_P = int'(64'(REF_HZ) / DEFAULT_HZ);

    logic             upd_valid;
    logic [CNT_W-1:0] upd_period;

    // Bits outside the select code and the speed flag carry no meaning here.
    logic ctrl_unused_bits;
    assign ctrl_unused_bits = ^{ctrl_word[31:DBL_POS+1], ctrl_word[DBL_POS-1:SEL_W]};

    srg_cfg_regs #(
        .REF_HZ (REF_HZ),
        .FREQ_W (FREQ_W),
        .CNT_W  (CNT_W)
    ) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .sel_in     (ctrl_word[SEL_W-1:0]),
        .dbl_in     (ctrl_word[DBL_POS]),
        .freq_wr    (freq_wr),
        .freq_in    (freq_word),
        .upd_valid  (upd_valid),
        .upd_period (upd_period),
        .cfg_err    (cfg_err)
    );

    srg_period_fsm #(
        .CNT_W  (CNT_W),
        .INIT_P (INIT_P)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .upd_period (upd_period),
        .strobe     (strobe),
        .period_out (period_out)
    );

endmodule

// File: tb/srg_strobe_gen_tb_top.sv
module srg_strobe_gen_tb_top;

    // A reference divisible by every standard rate keeps intervals short.
    localparam int unsigned REF = 14112000;
    localparam int          PW  = 17;   // interval width for a 16-bit frequency register

    localparam int P48  = REF / 48000;
    localparam int SMIN = (REF + 49999) / 50000;
    localparam int SMAX = REF / 25000;
    localparam int DMIN = (REF + 99999) / 100000;
    localparam int DMAX = REF / 50000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctrl_wr = 1'b0;
    logic [31:0]   ctrl_word = '0;
    logic          freq_wr = 1'b0;
    logic [15:0]   freq_word = '0;
    logic          strobe;
    logic [PW-1:0] period_out;
    logic          cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_p  = P48;

    always #5 clk = ~clk;

    srg_strobe_gen #(.REF_HZ(REF), .FREQ_W(16)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_word  (ctrl_word),
        .freq_wr    (freq_wr),
        .freq_word  (freq_word),
        .strobe     (strobe),
        .period_out (period_out),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Advances negedge by negedge until strobe is seen; returns the count.
    task automatic next_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!strobe && n < 5000);
    endtask

    // Called at a negedge; holds the write for one cycle.
    task automatic wr_cfg(input bit dc, input logic [31:0] c, input bit df, input logic [15:0] f);
        ctrl_wr = dc; ctrl_word = c; freq_wr = df; freq_word = f;
        @(negedge clk);
        ctrl_wr = 1'b0; freq_wr = 1'b0;
    endtask

    // Write in a strobe cycle, then measure the next interval.
    task automatic apply(input bit dc, input logic [31:0] c, input bit df, input logic [15:0] f,
                         input bit exp_err, input int exp_p, input string req);
        int n;
        next_strobe(n);
        wr_cfg(dc, c, df, f);
        check(cfg_err == exp_err, req, "cfg_err", cfg_err, exp_err);
        next_strobe(n);
        check(n + 1 == exp_p, req, "interval", n + 1, exp_p);
        check(int'(period_out) == exp_p, req, "period_out", period_out, exp_p);
        cur_p = exp_p;
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(period_out) == P48, "R1", "reset period_out", period_out, P48);
        check(cfg_err == 1'b0, "R1", "reset cfg_err", cfg_err, 0);
        check(strobe == 1'b0, "R1", "reset strobe", strobe, 0);
        rst = 1'b0;
        next_strobe(n);
        check(n + 1 == P48, "R1", "first strobe cycle", n + 1, P48);
        @(negedge clk);
        check(strobe == 1'b0, "R1", "strobe width", strobe, 0);
        next_strobe(n);
        check(n + 1 == P48, "R1", "second interval", n + 1, P48);
    endtask

    task automatic t_fixed_rates();
        int rates [7] = '{48000, 44100, 32000, 22050, 16000, 11025, 8000};
        for (int i = 0; i < 7; i++) begin
            apply(1, 32'(i + 2), 0, 16'h0, 0, REF / rates[i], "R2");
        end
        apply(1, 32'h4003, 0, 16'h0, 0, REF / 44100, "R2 double bit ignored");
    endtask

    task automatic t_double_codes();
        apply(1, 32'h4000, 0, 16'h0, 0, REF / 96000, "R3");
        apply(1, 32'h4001, 0, 16'h0, 0, REF / 88200, "R3");
        apply(1, 32'h0000, 0, 16'h0, 1, cur_p, "R3 reject");
        apply(1, 32'h0001, 0, 16'h0, 1, cur_p, "R3 reject");
    endtask

    task automatic t_bad_codes();
        int codes [6] = '{9, 10, 11, 12, 13, 15};
        for (int i = 0; i < 6; i++) begin
            apply(1, 32'(codes[i]) | 32'h4000, 0, 16'h0, 1, cur_p, "R4");
        end
        apply(1, 32'h2, 0, 16'h0, 0, P48, "R8 clear");
    endtask

    task automatic t_continuous();
        apply(0, 32'h0, 1, 16'd398, 0, P48, "R7 fixed mode");
        apply(1, 32'hE, 0, 16'h0, 0, 400, "R5");
        apply(0, 32'h0, 1, 16'd498, 0, 500, "R7 retune");
        apply(0, 32'h0, 1, 16'(SMIN - 2), 0, SMIN, "R6 single low edge");
        apply(0, 32'h0, 1, 16'(SMIN - 3), 1, SMIN, "R6 single below");
        apply(0, 32'h0, 1, 16'(SMAX - 2), 0, SMAX, "R6 single high edge");
        apply(0, 32'h0, 1, 16'(SMAX - 1), 1, SMAX, "R6 single above");
        apply(0, 32'h0, 1, 16'hFFFF, 1, SMAX, "R6 register max");
        apply(1, 32'h400E, 0, 16'h0, 1, SMAX, "R6 double with single value");
        apply(1, 32'h400E, 1, 16'(DMIN - 2), 0, DMIN, "R11");
        apply(0, 32'h0, 1, 16'(DMIN - 3), 1, DMIN, "R6 double below");
        apply(0, 32'h0, 1, 16'(DMAX - 2), 0, DMAX, "R6 double high edge");
        apply(0, 32'h0, 1, 16'(DMAX - 1), 1, DMAX, "R6 double above");
        apply(1, 32'h2, 0, 16'h0, 0, P48, "R8 clear");
    endtask

    task automatic t_mid_period();
        int n;
        next_strobe(n);
        repeat (10) @(negedge clk);
        wr_cfg(1, 32'h5, 0, 16'h0);
        next_strobe(n);
        check(10 + 1 + n == P48, "R9", "old interval kept", 11 + n, P48);
        check(int'(period_out) == P48, "R9", "period_out before boundary", period_out, P48);
        next_strobe(n);
        check(n == REF / 22050, "R9", "new interval", n, REF / 22050);
    endtask

    task automatic t_overwrite();
        int n;
        next_strobe(n);
        repeat (5) @(negedge clk);
        wr_cfg(1, 32'h3, 0, 16'h0);
        repeat (5) @(negedge clk);
        wr_cfg(1, 32'h4, 0, 16'h0);
        next_strobe(n);
        check(12 + n == REF / 22050, "R10", "interval with two writes", 12 + n, REF / 22050);
        next_strobe(n);
        check(n == REF / 32000, "R10", "later write wins", n, REF / 32000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "cycles", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_fixed_rates();
        t_double_codes();
        t_bad_codes();
        t_continuous();
        t_mid_period();
        t_overwrite();
        summary();
        $finish;
    end

endmodule